// File: doc/BRIEF.md
# Predicate-writing 32-bit compare unit

This unit evaluates one compare per clock. It compares the low 32 bits of two operands under one of ten relations and turns the one-bit outcome into writes to two predicate registers. The first operand is a register value, a sign-extended 8-bit immediate, or the constant zero. The second operand is always a register value. A compare-type field chooses how the outcome lands in the two destinations. The normal type writes the outcome and its inverse. The unconditional type also clears both destinations when the qualifying predicate is false. The and-type and or-type write only when the outcome allows it.

Only three relations exist in hardware: equal, signed less-than and unsigned less-than. The other seven are produced in one of two ways. The first is to exchange the two operands. The second is to invert the outcome, which is the same as exchanging the two destination writes. In immediate form, the four "plus one" relations get their constant by reading the field as the value minus one. The unit also reports illegal encodings and conflicting destinations on a fault flag. All results are registered, so they appear one cycle after the inputs.

Top module: `pcmp_unit`

## Requirements
- R1: Only bits 31:0 of each 64-bit operand take part in the compare. Bits 63:32 have no effect on any output.
- R2: Relation codes are: 0 eq, 1 ne, 2 lt, 3 le, 4 gt, 5 ge (all signed), and 6 ltu, 7 leu, 8 gtu, 9 geu (all unsigned). The outcome is 1 when "first operand relation second operand" holds. Codes 10 to 15 raise the fault whatever the qualifying predicate is.
- R3: Form code 0 takes the first operand from `src_a_i`. Form code 1 takes it from `imm_i`, sign-extended to 32 bits. Form code 2 uses zero. Form code 3 raises the fault whatever the qualifying predicate is.
- R4: In form 1 with le, gt, leu or gtu, the constant compared is the sign-extended field plus one, evaluated exactly with no 32-bit wrap. This gives -127..128 for the signed relations. For the unsigned relations it gives 1..128 and 2^32-127..2^32. With eq, ne, lt, ge, ltu and geu the constant is the sign-extended field itself, where unsigned compares read it as a 32-bit pattern.
- R5: Compare type 0 (normal) with qualifying predicate 1 writes the outcome to destination one and its inverse to destination two. With qualifying predicate 0 it writes nothing.
- R6: Compare type 1 (unconditional) with qualifying predicate 0 writes 0 to both destinations. With qualifying predicate 1 it behaves as type 0.
- R7: Compare type 2 (and) writes 0 to both destinations only when the qualifying predicate is 1 and the outcome is 0. Compare type 3 (or) writes 1 to both destinations only when the qualifying predicate is 1 and the outcome is 1.
- R8: Equal destination indices raise the fault when the qualifying predicate is 1 or the compare type is 1. A fault suppresses both writes.
- R9: Form 2 is legal only with compare type 2 or 3 and relation lt, le, gt or ge. Any other combination with form 2 raises the fault whatever the qualifying predicate is.
- R10: Predicate index 0 is constant. A destination with index 0 never has its write enable raised.
- R11: The outputs change on the clock edge after the inputs are presented, so latency is one cycle. A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qp_i | input | 1 | Qualifying predicate value |
| rel_i | input | 4 | Relation code (R2) |
| ctype_i | input | 2 | Compare type: 0 normal, 1 unconditional, 2 and, 3 or |
| form_i | input | 2 | First-operand form: 0 register, 1 immediate, 2 zero, 3 reserved |
| src_a_i | input | 64 | First register operand |
| src_b_i | input | 64 | Second register operand |
| imm_i | input | 8 | Immediate field |
| dst1_idx_i | input | 6 | First predicate destination index |
| dst2_idx_i | input | 6 | Second predicate destination index |
| dst1_we_o | output | 1 | Write enable for destination one |
| dst1_val_o | output | 1 | Value for destination one |
| dst1_idx_o | output | 6 | Registered index of destination one |
| dst2_we_o | output | 1 | Write enable for destination two |
| dst2_val_o | output | 1 | Value for destination two |
| dst2_idx_o | output | 6 | Registered index of destination two |
| fault_o | output | 1 | Illegal-operation fault |

## Verification
The unit keeps no state across compares other than its output registers. So any wrong operand exchange, outcome inversion, or immediate adjustment shows at the write values in the very next cycle after the offending inputs. The relations are swept across operand pairs at the signed and unsigned boundaries, and the immediate field is swept at -128, -1, 0, 127 and at the 2^32 edge. These sweeps make a wrong mapping for any single relation visible as a value or enable mismatch. A wrong fault condition shows as a raised or missing fault together with missing or stray write enables.

// File: rtl/pcmp_pkg.sv
// Shared encodings for the predicate-writing compare unit.
// Assumes the relation, type and form codes listed in the brief.
package pcmp_pkg;

    typedef enum logic [3:0] {
        REL_EQ  = 4'd0, REL_NE  = 4'd1, REL_LT  = 4'd2, REL_LE  = 4'd3,
        REL_GT  = 4'd4, REL_GE  = 4'd5, REL_LTU = 4'd6, REL_LEU = 4'd7,
        REL_GTU = 4'd8, REL_GEU = 4'd9
    } rel_e;

    typedef enum logic [1:0] {
        CT_NORM = 2'd0, CT_UNC = 2'd1, CT_AND = 2'd2, CT_OR = 2'd3
    } ctype_e;

    typedef enum logic [1:0] {
        FM_REG = 2'd0, FM_IMM = 2'd1, FM_ZERO = 2'd2, FM_RSVD = 2'd3
    } form_e;

    // Relations that exist in hardware.
    typedef enum logic [1:0] {
        NAT_EQ = 2'd0, NAT_LT = 2'd1, NAT_LTU = 2'd2
    } nat_e;

    typedef struct packed {
        logic we;
        logic val;
    } pwr_t;

endpackage

// File: rtl/pcmp_opsel.sv
// Operand selection and relation mapping.
// Picks the first operand by form. It then maps each of the ten relations onto
// eq / lt / ltu, an optional operand exchange, and an optional outcome inversion.
// Assumes that in immediate form the le/gt family reads the field as
// "constant minus one", so no adder is needed.
module pcmp_opsel
    import pcmp_pkg::*;
#(
    parameter int CW   = 32,
    parameter int IMMW = 8
) (
    input  logic [1:0]    form,
    input  logic [3:0]    rel,
    input  logic [CW-1:0] reg_a,
    input  logic [CW-1:0] reg_b,
    input  logic [IMMW-1:0] imm,
    output logic [CW-1:0] x,
    output logic [CW-1:0] y,
    output nat_e          op,
    output logic          inv,
    output logic          enc_bad
);
    localparam int EXTW = CW - IMMW;

    logic [CW-1:0] first;
    logic          is_imm;

    // Select the first operand according to the form code.
    always_comb begin
        unique case (form)
            FM_REG:  first = reg_a;
            FM_IMM:  first = {{EXTW{imm[IMMW-1]}}, imm};
            default: first = '0;
        endcase
    end

    assign is_imm = (form == FM_IMM);

    // Map the requested relation onto a native one plus exchange/inversion.
    always_comb begin
        x       = first;
        y       = reg_b;
        op      = NAT_EQ;
        inv     = 1'b0;
        enc_bad = (form == FM_RSVD);
        case (rel)
            REL_EQ: ;
            REL_NE: inv = 1'b1;
            REL_LT: op = NAT_LT;
            REL_GE: begin op = NAT_LT; inv = 1'b1; end
            REL_LTU: op = NAT_LTU;
            REL_GEU: begin op = NAT_LTU; inv = 1'b1; end
            REL_LE, REL_LEU: begin
                op = (rel == REL_LE) ? NAT_LT : NAT_LTU;
                if (!is_imm) begin
                    x   = reg_b;
                    y   = first;
                    inv = 1'b1;
                end
            end
            REL_GT, REL_GTU: begin
                op = (rel == REL_GT) ? NAT_LT : NAT_LTU;
                if (is_imm) begin
                    inv = 1'b1;
                end else begin
                    x = reg_b;
                    y = first;
                end
            end
            default: enc_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/pcmp_core.sv
// Native comparator: equal, signed less-than, unsigned less-than on CW bits.
// Assumes the operands are already selected and ordered.
module pcmp_core
    import pcmp_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  nat_e          op,
    output logic          res
);
    // Evaluate the selected native relation.
    always_comb begin
        unique case (op)
            NAT_LT:  res = ($signed(x) < $signed(y));
            NAT_LTU: res = (x < y);
            default: res = (x == y);
        endcase
    end
endmodule

// File: rtl/pcmp_wgen.sv
// Predicate write generation.
// Turns the outcome, qualifying predicate and compare type into two
// (enable, value) pairs. Suppresses both on a fault and drops writes to index 0.
module pcmp_wgen
    import pcmp_pkg::*;
#(
    parameter int PIDXW = 6
) (
    input  logic             qp,
    input  logic [1:0]       ctype,
    input  logic             res,
    input  logic             fault,
    input  logic [PIDXW-1:0] idx1,
    input  logic [PIDXW-1:0] idx2,
    output pwr_t             w1,
    output pwr_t             w2
);
    // Apply the compare-type write rules, then the index-zero rule.
    always_comb begin
        w1 = '0;
        w2 = '0;
        if (!fault) begin
            unique case (ctype)
                CT_NORM: if (qp) begin
                    w1 = '{we: 1'b1, val: res};
                    w2 = '{we: 1'b1, val: ~res};
                end
                CT_UNC: begin
                    w1 = '{we: 1'b1, val: qp & res};
                    w2 = '{we: 1'b1, val: qp & ~res};
                end
                CT_AND: if (qp && !res) begin
                    w1 = '{we: 1'b1, val: 1'b0};
                    w2 = '{we: 1'b1, val: 1'b0};
                end
                default: if (qp && res) begin
                    w1 = '{we: 1'b1, val: 1'b1};
                    w2 = '{we: 1'b1, val: 1'b1};
                end
            endcase
        end
        if (idx1 == '0) w1.we = 1'b0;
        if (idx2 == '0) w2.we = 1'b0;
    end
endmodule

// File: rtl/pcmp_unit.sv
// Predicate-writing 32-bit compare unit (top).
// Combines operand mapping, native compare and write generation. All outputs
// are registered, so latency is one cycle. Synchronous active-low reset.
// Assumes one compare is presented every cycle.
module pcmp_unit
    import pcmp_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CW    = 32,
    parameter int IMMW  = 8,
    parameter int PIDXW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qp_i,
    input  logic [3:0]       rel_i,
    input  logic [1:0]       ctype_i,
    input  logic [1:0]       form_i,
    input  logic [XLEN-1:0]  src_a_i,
    input  logic [XLEN-1:0]  src_b_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic [PIDXW-1:0] dst1_idx_i,
    input  logic [PIDXW-1:0] dst2_idx_i,
    output logic             dst1_we_o,
    output logic             dst1_val_o,
    output logic [PIDXW-1:0] dst1_idx_o,
    output logic             dst2_we_o,
    output logic             dst2_val_o,
    output logic [PIDXW-1:0] dst2_idx_o,
    output logic             fault_o
);
    logic [CW-1:0] cx, cy;
    nat_e          nop;
    logic          ninv, enc_bad, nres, outcome;
    logic          zero_bad, same_dst, fault_c;
    pwr_t          w1, w2;
    logic          unused_hi;

    // Upper operand halves are not part of the compare.
    assign unused_hi = ^{src_a_i[XLEN-1:CW], src_b_i[XLEN-1:CW]};

    pcmp_opsel #(.CW(CW), .IMMW(IMMW)) u_opsel (
        .form    (form_i),
        .rel     (rel_i),
        .reg_a   (src_a_i[CW-1:0]),
        .reg_b   (src_b_i[CW-1:0]),
        .imm     (imm_i),
        .x       (cx),
        .y       (cy),
        .op      (nop),
        .inv     (ninv),
        .enc_bad (enc_bad)
    );

    pcmp_core #(.CW(CW)) u_core (
        .x   (cx),
        .y   (cy),
        .op  (nop),
        .res (nres)
    );

    assign outcome = nres ^ ninv;

    // Fault sources: illegal encodings, zero-form misuse, conflicting destinations.
    always_comb begin
        zero_bad = (form_i == FM_ZERO) &&
                   !(((ctype_i == CT_AND) || (ctype_i == CT_OR)) &&
                     ((rel_i == REL_LT) || (rel_i == REL_LE) ||
                      (rel_i == REL_GT) || (rel_i == REL_GE)));
        same_dst = (dst1_idx_i == dst2_idx_i) && (qp_i || (ctype_i == CT_UNC));
        fault_c  = enc_bad || zero_bad || same_dst;
    end

    pcmp_wgen #(.PIDXW(PIDXW)) u_wgen (
        .qp    (qp_i),
        .ctype (ctype_i),
        .res   (outcome),
        .fault (fault_c),
        .idx1  (dst1_idx_i),
        .idx2  (dst2_idx_i),
        .w1    (w1),
        .w2    (w2)
    );

    // Register the write requests, indices and fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst1_we_o  <= 1'b0;
            dst1_val_o <= 1'b0;
            dst1_idx_o <= '0;
            dst2_we_o  <= 1'b0;
            dst2_val_o <= 1'b0;
            dst2_idx_o <= '0;
            fault_o    <= 1'b0;
        end else begin
            dst1_we_o  <= w1.we;
            dst1_val_o <= w1.val;
            dst1_idx_o <= dst1_idx_i;
            dst2_we_o  <= w2.we;
            dst2_val_o <= w2.val;
            dst2_idx_o <= dst2_idx_i;
            fault_o    <= fault_c;
        end
    end
endmodule

// File: rtl/pcmp_unit_chk.sv
// Property checker for pcmp_unit, attached by bind.
// Relates registered outputs to the inputs of the previous cycle. A one-cycle
// "settled" flag keeps $past away from values captured during reset.
module pcmp_unit_chk
    import pcmp_pkg::*;
#(
    parameter int PIDXW = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             qp_i,
    input logic [1:0]       ctype_i,
    input logic [PIDXW-1:0] dst1_idx_i,
    input logic [PIDXW-1:0] dst2_idx_i,
    input logic             dst1_we_o,
    input logic             dst1_val_o,
    input logic [PIDXW-1:0] dst1_idx_o,
    input logic             dst2_we_o,
    input logic             dst2_val_o,
    input logic [PIDXW-1:0] dst2_idx_o,
    input logic             fault_o
);
    logic settled;

    // Mark cycles whose previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) settled <= 1'b0;
        else        settled <= 1'b1;
    end

    p_pr0_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dst1_we_o |-> dst1_idx_o != '0) and (dst2_we_o |-> dst2_idx_o != '0));

    p_fault_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !dst1_we_o && !dst2_we_o);

    p_same_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        settled && ($past(dst1_idx_i) == $past(dst2_idx_i)) && $past(qp_i) |-> fault_o);

    p_normal_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        settled && ($past(ctype_i) == CT_NORM) && $past(qp_i) && dst1_we_o && dst2_we_o
        |-> dst1_val_o != dst2_val_o);

    p_normal_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        settled && ($past(ctype_i) == CT_NORM) && !$past(qp_i)
        |-> !dst1_we_o && !dst2_we_o);

    p_unc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        settled && ($past(ctype_i) == CT_UNC) && !$past(qp_i) && !fault_o
        |-> !dst1_val_o && !dst2_val_o);

    p_par_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        settled && (($past(ctype_i) == CT_AND) || ($past(ctype_i) == CT_OR)) &&
        dst1_we_o && dst2_we_o |-> dst1_val_o == dst2_val_o);

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> (dst1_idx_o == $past(dst1_idx_i)) && (dst2_idx_o == $past(dst2_idx_i)));
endmodule

bind pcmp_unit pcmp_unit_chk #(.PIDXW(PIDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .qp_i       (qp_i),
    .ctype_i    (ctype_i),
    .dst1_idx_i (dst1_idx_i),
    .dst2_idx_i (dst2_idx_i),
    .dst1_we_o  (dst1_we_o),
    .dst1_val_o (dst1_val_o),
    .dst1_idx_o (dst1_idx_o),
    .dst2_we_o  (dst2_we_o),
    .dst2_val_o (dst2_val_o),
    .dst2_idx_o (dst2_idx_o),
    .fault_o    (fault_o)
);

// File: tb/pcmp_unit_test.sv
// Directed bench for pcmp_unit: one task per scenario, each checks its own vectors.
module pcmp_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        qp = 1'b0;
    logic [3:0]  rel = '0;
    logic [1:0]  ct = '0;
    logic [1:0]  fm = '0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic [7:0]  imm = '0;
    logic [5:0]  i1 = 6'd1;
    logic [5:0]  i2 = 6'd2;
    logic        we1, v1, we2, v2, flt;
    logic [5:0]  o1, o2;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    pcmp_unit uut (
        .clk(clk), .rst_n(rst_n), .qp_i(qp), .rel_i(rel), .ctype_i(ct), .form_i(fm),
        .src_a_i(a), .src_b_i(b), .imm_i(imm), .dst1_idx_i(i1), .dst2_idx_i(i2),
        .dst1_we_o(we1), .dst1_val_o(v1), .dst1_idx_o(o1),
        .dst2_we_o(we2), .dst2_val_o(v2), .dst2_idx_o(o2), .fault_o(flt)
    );

    // Reference model built from the requirements.
    function automatic void model(input bit q, input bit [3:0] rl, input bit [1:0] c,
                                  input bit [1:0] f, input bit [63:0] sa, input bit [63:0] sb,
                                  input bit [7:0] im, input bit [5:0] d1, input bit [5:0] d2,
                                  output bit ef, output bit ew1, output bit ev1,
                                  output bit ew2, output bit ev2);
        longint xs, xu, ys, yu;
        bit res, bad;
        ys = longint'($signed(sb[31:0]));
        yu = longint'({32'h0, sb[31:0]});
        xs = 0;
        xu = 0;
        if (f == 2'd0) begin
            xs = longint'($signed(sa[31:0]));
            xu = longint'({32'h0, sa[31:0]});
        end else if (f == 2'd1) begin
            xs = longint'($signed(im));
            xu = xs & 64'h0000_0000_FFFF_FFFF;
            if (rl == 3 || rl == 4 || rl == 7 || rl == 8) begin
                xs = xs + 1;
                xu = xu + 1;
            end
        end
        case (rl)
            4'd0: res = (xs == ys);
            4'd1: res = (xs != ys);
            4'd2: res = (xs < ys);
            4'd3: res = (xs <= ys);
            4'd4: res = (xs > ys);
            4'd5: res = (xs >= ys);
            4'd6: res = (xu < yu);
            4'd7: res = (xu <= yu);
            4'd8: res = (xu > yu);
            4'd9: res = (xu >= yu);
            default: res = 1'b0;
        endcase
        bad = (rl > 4'd9) || (f == 2'd3) ||
              (f == 2'd2 && !((c == 2'd2 || c == 2'd3) && rl >= 4'd2 && rl <= 4'd5));
        ef = bad || (d1 == d2 && (q || c == 2'd1));
        ew1 = 0; ev1 = 0; ew2 = 0; ev2 = 0;
        if (!ef) begin
            case (c)
                2'd0: if (q) begin ew1 = 1; ev1 = res; ew2 = 1; ev2 = !res; end
                2'd1: begin ew1 = 1; ew2 = 1; if (q) begin ev1 = res; ev2 = !res; end end
                2'd2: if (q && !res) begin ew1 = 1; ew2 = 1; end
                default: if (q && res) begin ew1 = 1; ew2 = 1; ev1 = 1; ev2 = 1; end
            endcase
        end
        if (d1 == 0) ew1 = 0;
        if (d2 == 0) ew2 = 0;
    endfunction

    // Drive one compare at a falling edge and check the outputs one cycle later.
    task automatic apply(input string tag, input bit q, input bit [3:0] rl, input bit [1:0] c,
                         input bit [1:0] f, input bit [63:0] sa, input bit [63:0] sb,
                         input bit [7:0] im, input bit [5:0] d1, input bit [5:0] d2);
        bit ef, ew1, ev1, ew2, ev2, ok;
        @(negedge clk);
        qp = q; rel = rl; ct = c; fm = f; a = sa; b = sb; imm = im; i1 = d1; i2 = d2;
        model(q, rl, c, f, sa, sb, im, d1, d2, ef, ew1, ev1, ew2, ev2);
        @(negedge clk);
        ok = (flt == ef) && (we1 == ew1) && (we2 == ew2) && (o1 == d1) && (o2 == d2) &&
             (!ew1 || v1 == ev1) && (!ew2 || v2 == ev2);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s rel=%0d ct=%0d form=%0d qp=%0b a=%h b=%h imm=%h: got f%0b w%0b%0b v%0b%0b i%0d/%0d exp f%0b w%0b%0b v%0b%0b i%0d/%0d",
                     tag, rl, c, f, q, sa, sb, im, flt, we1, we2, v1, v2, o1, o2,
                     ef, ew1, ew2, ev1, ev2, d1, d2);
        end
    endtask

    task automatic check_zero(input string tag);
        n_chk++;
        if ({we1, v1, we2, v2, flt, o1, o2} != '0) begin
            n_bad++;
            $display("FAIL %s: got we%0b%0b v%0b%0b f%0b i%0d/%0d exp all zero",
                     tag, we1, we2, v1, v2, flt, o1, o2);
        end
    endtask

    localparam bit [63:0] VALS [6] = '{64'h0, 64'h1, 64'hAAAA_0000_FFFF_FFFF,
                                       64'h0000_0001_8000_0000, 64'h7FFF_FFFF,
                                       64'h5555_5555_0000_0080};

    // R11: reset state and reset taking effect mid-run.
    task automatic t_reset();
        qp = 1; ct = 0; fm = 0; rel = 0; i1 = 6'd3; i2 = 6'd4;
        repeat (3) @(negedge clk);
        check_zero("R11 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_zero("R11 reset mid-run");
        rst_n = 1'b1;
    endtask

    // R2 R1: every relation in register form over boundary pairs.
    task automatic t_reg_relations();
        foreach (VALS[x]) foreach (VALS[y])
            for (int r = 0; r < 10; r++)
                apply("R2 register relation", 1'b1, 4'(r), 2'd0, 2'd0, VALS[x], VALS[y],
                      8'h0, 6'd5, 6'd6);
    endtask

    // R1: upper halves differ, low halves equal.
    task automatic t_upper_ignored();
        apply("R1 eq high bits", 1, 4'd0, 2'd0, 2'd0, 64'hDEAD_0000_0000_0005,
              64'h1234_0000_0000_0005, 8'h0, 6'd7, 6'd8);
        apply("R1 ltu high bits", 1, 4'd6, 2'd0, 2'd0, 64'h0000_0000_0000_0009,
              64'hFFFF_FFFF_0000_0003, 8'h0, 6'd7, 6'd8);
        apply("R1 lt high bits", 1, 4'd2, 2'd1, 2'd0, 64'h0, 64'h8000_0000_8000_0000,
              8'h0, 6'd7, 6'd8);
    endtask

    // R3 R4: immediate form at the edges of the field.
    task automatic t_imm();
        bit [7:0]  ims [6] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h01, 8'hFE};
        bit [31:0] bs  [10] = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'h81, 32'hFFFF_FF80,
                                32'hFFFF_FF7F, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
        foreach (ims[m]) foreach (bs[k])
            for (int r = 0; r < 10; r++)
                apply("R4 immediate relation", 1, 4'(r), 2'd0, 2'd1, 64'hFFFF_0000_1234_5678,
                      {32'h0BAD_F00D, bs[k]}, ims[m], 6'd9, 6'd10);
    endtask

    // R5 R6 R7: compare types under both predicate values and both outcomes.
    task automatic t_ctypes();
        for (int c = 0; c < 4; c++)
            for (int q = 0; q < 2; q++)
                for (int r = 2; r < 6; r++) begin
                    apply("R5 R6 R7 type reg", q[0], 4'(r), 2'(c), 2'd0, 64'd3, 64'd7,
                          8'h0, 6'd11, 6'd12);
                    apply("R5 R6 R7 type imm", q[0], 4'(r), 2'(c), 2'd1, 64'd0, 64'd7,
                          8'h07, 6'd13, 6'd14);
                end
    endtask

    // R8: same destination with each predicate value and type.
    task automatic t_same_dest();
        for (int c = 0; c < 4; c++)
            for (int q = 0; q < 2; q++)
                apply("R8 same destination", q[0], 4'd2, 2'(c), 2'd0, 64'd1, 64'd2,
                      8'h0, 6'd20, 6'd20);
    endtask

    // R9: zero form across all types and relations.
    task automatic t_zero_form();
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 10; r++) begin
                apply("R9 zero form pos", 1, 4'(r), 2'(c), 2'd2, 64'hFFFF, 64'd5,
                      8'h0, 6'd21, 6'd22);
                apply("R9 zero form neg", 1, 4'(r), 2'(c), 2'd2, 64'd0, 64'hFFFF_FFF0,
                      8'h0, 6'd21, 6'd22);
            end
        apply("R9 zero form qp0", 0, 4'd0, 2'd0, 2'd2, 64'd0, 64'd0, 8'h0, 6'd21, 6'd22);
    endtask

    // R10: index 0 never receives a write.
    task automatic t_pr0();
        apply("R10 dst1 index 0", 1, 4'd0, 2'd0, 2'd0, 64'd4, 64'd4, 8'h0, 6'd0, 6'd30);
        apply("R10 dst2 index 0", 1, 4'd1, 2'd1, 2'd0, 64'd4, 64'd4, 8'h0, 6'd31, 6'd0);
        apply("R10 or index 0", 1, 4'd0, 2'd3, 2'd0, 64'd4, 64'd4, 8'h0, 6'd0, 6'd15);
    endtask

    // R2 R3: reserved relation and form codes.
    task automatic t_reserved();
        for (int r = 10; r < 16; r++)
            for (int q = 0; q < 2; q++)
                apply("R2 reserved relation", q[0], 4'(r), 2'd0, 2'd0, 64'd1, 64'd2,
                      8'h0, 6'd16, 6'd17);
        apply("R3 reserved form", 0, 4'd2, 2'd0, 2'd3, 64'd1, 64'd2, 8'h0, 6'd16, 6'd17);
        apply("R3 reserved form qp", 1, 4'd0, 2'd3, 2'd3, 64'd1, 64'd1, 8'h0, 6'd16, 6'd17);
    endtask

    initial begin
        t_reset();
        t_reg_relations();
        t_upper_ignored();
        t_imm();
        t_ctypes();
        t_same_dest();
        t_zero_form();
        t_pr0();
        t_reserved();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule